// File: doc/BRIEF.md
# Six-Step Register-Transfer Processor Core

This block is a small processor core that performs exactly one register transfer per clock. An instruction is brought in through an address latch, a data latch and an instruction latch. It is then executed as an ALU operation between a register and an immediate. The result is written back to a destination register and, optionally, to a four-bit status word. The core has sixteen 32-bit registers. Register 13 is the stack pointer, register 14 the link register and register 15 the program counter.

Program memory sits outside the core. It is a synchronous word memory with one cycle of read latency, addressed in bytes. Every instruction takes the same six clocks: address latch, memory read, data capture, instruction load, operand load and write-back. Debug outputs expose the register file, the status word and the instruction latch, so a system or a bench can follow execution.

Top module: `fes_core`

## Requirements
- R1: While `rst_n` is low, every register is held at zero, including the program counter. The address latch, data latch, instruction latch and status word are also zero. The core begins with the address step when reset is released.
- R2: In the address step the program counter is copied to `mem_addr`, and the program counter advances by 4 in the same clock.
- R3: `mem_rd` is high for exactly one clock of the six, the clock after the address step, and it is low during reset. The read data is expected on `mem_rdata` one clock later.
- R4: The word read from memory is captured in the data latch and moved to the instruction latch (`dbg_ir`) on the following clock, so each instruction occupies six clocks.
- R5: The instruction word is laid out as follows: bits 31:28 op-code, bit 27 set-status, bits 26:23 destination, bits 22:19 source, bits 18:12 ignored, bits 11:0 an immediate that is zero-extended.
- R6: The op-codes are 0 = copy immediate, 1 = add, 2 = subtract (source minus immediate), 3 = AND, 4 = OR and 5 = XOR. The result is written to the destination register in the last step.
- R7: `dbg_flags` = {N, Z, C, V}. It changes only at write-back of a defined op-code whose set-status bit is 1. N is result bit 31 and Z means the result is zero. For add, C is the carry out. For subtract, C is 1 when a borrow occurred (source < immediate, unsigned). V is signed overflow. Copy and the logic ops leave C and V unchanged.
- R8: Op-codes 6 to 15 write no register and no status, whatever their set-status bit.
- R9: Register 15 used as a source gives the already advanced program counter. Register 15 as a destination redirects the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | 32 | Program memory read data, valid one clock after `mem_rd` |
| mem_addr | output | 32 | Byte address of the instruction being fetched (address latch) |
| mem_rd | output | 1 | Program memory read strobe |
| dbg_regs | output | 512 | Register file, register i at bits i*32+31 : i*32 |
| dbg_flags | output | 4 | Status word {N, Z, C, V} |
| dbg_ir | output | 32 | Instruction latch |

## Verification
The bench runs a program that includes several edge cases:
- A subtract below zero, which must set borrow and negative. A design with the carry sense inverted would report C the wrong way round.
- An add that wraps to zero, which must set zero and carry.
- A subtract without the set-status bit. A design that ignored the bit would overwrite the status word.
- An AND after these, which must keep the old C. A design that cleared C and V on logic ops would lose it.
- An undefined op-code aimed at a live register with the set-status bit set. A design without the op-code guard would corrupt that register.
- A read of register 15 and a jump written into register 15. A core that advanced the program counter late would store the wrong link value. A core that ignored the write would not loop back to address 0.

A reset applied in the middle of the program checks that no state survives it.

// File: rtl/fes_pkg.sv
package fes_pkg;

  typedef enum logic [2:0] {
    ST_FADDR = 3'd0,
    ST_FREAD = 3'd1,
    ST_FCAP  = 3'd2,
    ST_DEC   = 3'd3,
    ST_EOPS  = 3'd4,
    ST_EWB   = 3'd5
  } fes_state_e;

  typedef enum logic [3:0] {
    OP_MOV = 4'd0,
    OP_ADD = 4'd1,
    OP_SUB = 4'd2,
    OP_AND = 4'd3,
    OP_ORR = 4'd4,
    OP_EOR = 4'd5
  } fes_op_e;

  // instruction field positions
  localparam int OPC_LO = 28;
  localparam int OPC_W  = 4;
  localparam int SET_B  = 27;
  localparam int DST_LO = 23;
  localparam int SRC_LO = 19;
  localparam int IMM_W  = 12;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } fes_flags_t;

endpackage

// File: rtl/fes_ctrl.sv
module fes_ctrl
  import fes_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  output fes_state_e state
);

  fes_state_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      ST_FADDR: state_d = ST_FREAD;
      ST_FREAD: state_d = ST_FCAP;
      ST_FCAP:  state_d = ST_DEC;
      ST_DEC:   state_d = ST_EOPS;
      ST_EOPS:  state_d = ST_EWB;
      default:  state_d = ST_FADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FADDR;
    else        state <= state_d;
  end

  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(state) == ST_FREAD |-> state == ST_FCAP); // R4

endmodule

// File: rtl/fes_regfile.sv
module fes_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int RAW = $clog2(NREG),
  localparam int PCI = NREG - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [RAW-1:0]   waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             pc_inc,
  input  logic [RAW-1:0]   raddr,
  output logic [DW-1:0]    rdata,
  output logic [DW-1:0]    pc,
  output logic [NREG*DW-1:0] dbg
);

  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          wr_hit;
    logic [DW-1:0] nxt;
    logic          en;

    always_comb begin
      wr_hit = we && (waddr == RAW'(g));
      nxt    = wdata;
      en     = wr_hit;
      if (g == PCI && pc_inc) begin
        nxt = regs_q[g] + DW'(4);
        en  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[g] <= '0;
      else if (en) regs_q[g] <= nxt;
    end

    assign dbg[g*DW +: DW] = regs_q[g];
  end

  assign rdata = regs_q[raddr];
  assign pc    = regs_q[PCI];

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(pc_inc) |-> pc == $past(pc) + DW'(4)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(we) && !$past(pc_inc) |-> $stable(dbg)); // R8

endmodule

// File: rtl/fes_alu.sv
module fes_alu
  import fes_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [OPC_W-1:0] op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  output logic [DW-1:0]    res,
  output logic             fn,
  output logic             fz,
  output logic             fc,
  output logic             fv,
  output logic             valid,
  output logic             arith
);

  logic          sub;
  logic [DW-1:0] bb;
  logic [DW:0]   sum;

  assign sub = (op == OP_SUB);
  assign bb  = sub ? ~b : b;
  assign sum = {1'b0, a} + {1'b0, bb} + {{DW{1'b0}}, sub};

  always_comb begin
    res   = '0;
    valid = 1'b1;
    arith = 1'b0;
    case (op)
      OP_MOV: res = b;
      OP_ADD: begin res = sum[DW-1:0]; arith = 1'b1; end
      OP_SUB: begin res = sum[DW-1:0]; arith = 1'b1; end
      OP_AND: res = a & b;
      OP_ORR: res = a | b;
      OP_EOR: res = a ^ b;
      default: valid = 1'b0;
    endcase
  end

  assign fn = res[DW-1];
  assign fz = (res == '0);
  assign fc = sub ? ~sum[DW] : sum[DW];
  assign fv = (a[DW-1] ^ res[DW-1]) & ~(a[DW-1] ^ bb[DW-1]);

endmodule

// File: rtl/fes_core.sv
module fes_core
  import fes_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        mem_rdata,
  output logic [DW-1:0]        mem_addr,
  output logic                 mem_rd,
  output logic [NREG*DW-1:0]   dbg_regs,
  output logic [3:0]           dbg_flags,
  output logic [DW-1:0]        dbg_ir
);

  localparam int RAW = $clog2(NREG);

  fes_state_e    state;
  logic [DW-1:0] mar_q, mbr_q, ir_q, opa_q, opb_q;
  fes_flags_t    flg_q;
  logic [DW-1:0] pc, rf_rdata, alu_res;
  logic          ld_mar, ld_mbr, ld_ir, ld_ops, wb;
  logic          rf_we, flag_we;
  logic          a_n, a_z, a_c, a_v, a_valid, a_arith;

  fes_ctrl i_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state)
  );

  assign ld_mar = (state == ST_FADDR);
  assign mem_rd = (state == ST_FREAD);
  assign ld_mbr = (state == ST_FCAP);
  assign ld_ir  = (state == ST_DEC);
  assign ld_ops = (state == ST_EOPS);
  assign wb     = (state == ST_EWB);

  fes_regfile #(.DW(DW), .NREG(NREG)) i_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (rf_we),
    .waddr  (ir_q[DST_LO +: RAW]),
    .wdata  (alu_res),
    .pc_inc (ld_mar),
    .raddr  (ir_q[SRC_LO +: RAW]),
    .rdata  (rf_rdata),
    .pc     (pc),
    .dbg    (dbg_regs)
  );

  fes_alu #(.DW(DW)) i_alu (
    .op    (ir_q[OPC_LO +: OPC_W]),
    .a     (opa_q),
    .b     (opb_q),
    .res   (alu_res),
    .fn    (a_n),
    .fz    (a_z),
    .fc    (a_c),
    .fv    (a_v),
    .valid (a_valid),
    .arith (a_arith)
  );

  assign rf_we   = wb && a_valid;
  assign flag_we = rf_we && ir_q[SET_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      opa_q <= '0;
      opb_q <= '0;
    end else begin
      if (ld_mar) mar_q <= pc;
      if (ld_mbr) mbr_q <= mem_rdata;
      if (ld_ir)  ir_q  <= mbr_q;
      if (ld_ops) begin
        opa_q <= rf_rdata;
        opb_q <= DW'(ir_q[IMM_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
    end else if (flag_we) begin
      flg_q.n <= a_n;
      flg_q.z <= a_z;
      if (a_arith) begin
        flg_q.c <= a_c;
        flg_q.v <= a_v;
      end
    end
  end

  assign mem_addr  = mar_q;
  assign dbg_flags = flg_q;
  assign dbg_ir    = ir_q;

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd); // R3

  AST_RD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> pc == mem_addr + DW'(4)); // R2

  AST_CAPTURE_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(mem_rd) |-> ld_mbr); // R4

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(dbg_flags)); // R7

endmodule

// File: tb/test_fes_core.sv
module test_fes_core;

  localparam int CLK_P = 10;
  localparam int DW    = 32;
  localparam int NREG  = 16;

  logic                clk;
  logic                rst_n;
  logic [DW-1:0]       mem_rdata;
  logic [DW-1:0]       mem_addr;
  logic                mem_rd;
  logic [NREG*DW-1:0]  dbg_regs;
  logic [3:0]          dbg_flags;
  logic [DW-1:0]       dbg_ir;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;
  bit cmp_on  = 0;

  fes_core #(.DW(DW), .NREG(NREG)) i_fes_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .dbg_regs  (dbg_regs),
    .dbg_flags (dbg_flags),
    .dbg_ir    (dbg_ir)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // program memory, one cycle read latency
  logic [31:0] mem [64];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:2]];

  function automatic logic [31:0] enc(int op, int s, int rd, int rn, int imm);
    return {op[3:0], s[0], rd[3:0], rn[3:0], 7'd0, imm[11:0]};
  endfunction

  // behavioural reference model
  int          ph;
  logic [31:0] m_r [16];
  logic [31:0] m_mar, m_mbr, m_ir, m_a, m_b;
  logic [3:0]  m_f;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; m_mar = 0; m_mbr = 0; m_ir = 0; m_a = 0; m_b = 0; m_f = 0;
      for (int i = 0; i < 16; i++) m_r[i] = 0;
    end else begin
      case (ph)
        0: begin m_mar = m_r[15]; m_r[15] = m_r[15] + 4; end
        2: m_mbr = mem[m_mar[7:2]];
        3: m_ir = m_mbr;
        4: begin m_a = m_r[m_ir[22:19]]; m_b = {20'd0, m_ir[11:0]}; end
        5: begin
          int op; logic [31:0] r; bit ok, ar; logic c, v; longint w;
          op = int'(m_ir[31:28]); ok = 1; ar = 0; r = 0; c = 0; v = 0;
          case (op)
            0: r = m_b;
            1: begin w = longint'(m_a) + longint'(m_b); r = w[31:0];
                     c = w[32]; ar = 1;
                     v = (m_a[31] == m_b[31]) && (r[31] != m_a[31]); end
            2: begin r = m_a - m_b; c = (m_a < m_b); ar = 1;
                     v = (m_a[31] != m_b[31]) && (r[31] != m_a[31]); end
            3: r = m_a & m_b;
            4: r = m_a | m_b;
            5: r = m_a ^ m_b;
            default: ok = 0;
          endcase
          if (ok) begin
            m_r[m_ir[26:23]] = r;
            if (m_ir[27]) begin
              m_f[3] = r[31];
              m_f[2] = (r == 0);
              if (ar) begin m_f[1] = c; m_f[0] = v; end
            end
          end
        end
        default: ;
      endcase
      ph = (ph == 5) ? 0 : ph + 1;
    end
  end

  task automatic chk(string req, logic [511:0] act, logic [511:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] model_regs();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = m_r[i];
    return v;
  endfunction

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R3 read strobe", 512'(mem_rd), 512'(rst_n && ph == 1));
      chk("R2 address",     512'(mem_addr), 512'(m_mar));
      chk("R4 instruction", 512'(dbg_ir), 512'(m_ir));
      chk("R6 registers",   dbg_regs, model_regs());
      chk("R7 flags",       512'(dbg_flags), 512'(m_f));
    end
  end

  function automatic logic [31:0] rg(int i);
    return dbg_regs[i*32 +: 32];
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = enc(15, 1, 1, 1, 12'hABC);
    mem[0]  = enc(0, 1, 1, 0, 12'hFFF);   // copy
    mem[1]  = enc(1, 1, 2, 1, 1);         // add
    mem[2]  = enc(2, 1, 3, 0, 1);         // subtract below zero
    mem[3]  = enc(1, 1, 4, 3, 1);         // add wraps to zero
    mem[4]  = enc(2, 0, 5, 2, 12'h800);   // subtract, status untouched
    mem[5]  = enc(3, 1, 6, 3, 12'h0F0);   // AND keeps C,V
    mem[6]  = enc(4, 0, 7, 1, 12'h00F);   // OR
    mem[7]  = enc(5, 1, 8, 3, 12'h555);   // XOR
    mem[8]  = enc(9, 1, 1, 0, 0);         // undefined op-code
    mem[9]  = enc(0, 0, 13, 0, 12'h100);
    mem[10] = enc(1, 0, 14, 15, 0);       // read PC
    mem[11] = enc(2, 1, 9, 1, 12'hFFF);   // zero, no borrow
    mem[12] = enc(0, 0, 15, 0, 0);        // jump to 0

    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp_on = 1;
    // R1: reset state
    chk("R1 regs zero", dbg_regs, '0);
    chk("R1 ir/addr/flags zero", 512'({dbg_ir, mem_addr, dbg_flags}), '0);
    chk("R3 no strobe in reset", 512'(mem_rd), '0);
    #(CLK_P/4) rst_n = 1'b1;

    repeat (78) @(posedge clk);
    @(negedge clk);
    chk("R5 R6 add result r2", 512'(rg(2)), 512'(32'h1000));
    chk("R6 xor result r8", 512'(rg(8)), 512'(32'hFFFFFAAA));
    chk("R6 subtract result r5", 512'(rg(5)), 512'(32'h800));
    chk("R8 undefined op left r1", 512'(rg(1)), 512'(32'hFFF));
    chk("R9 link read of PC", 512'(rg(14)), 512'(32'h2C));
    chk("R9 jump to zero", 512'(rg(15)), 512'(32'h0));
    chk("R7 flags after final subtract", 512'(dbg_flags), 512'(4'b0100));

    repeat (250) @(posedge clk);
    @(negedge clk);
    #(CLK_P/4) rst_n = 1'b0;
    #1;
    chk("R1 mid-run reset regs", dbg_regs, '0);
    chk("R1 mid-run reset flags", 512'(dbg_flags), '0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    #(CLK_P/4) rst_n = 1'b1;
    repeat (100) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule